// File: doc/BRIEF.md
# Relocatable Interrupt Vector Controller

This block arbitrates among twenty interrupt request sources and turns the winner into the program-memory word address that the processor fetches next. It also supplies the address fetched after reset. Both addresses can sit in the application region at the bottom of memory or in the boot region, which starts at word `0x3800` by default. A strap input (`boot_fuse_n`) picks where reset goes. A vector-select bit in a small control register picks where the interrupt table lives.

The control register is written over a plain write-enable/data bus and read back through a combinational port. The vector-select bit is guarded by an unlock sequence. Software first writes 1 to the change-enable bit. It then writes the new vector-select value, with change-enable at 0, inside the next four cycles. While this sequence is open, interrupt dispatch is held off in hardware. The global interrupt-enable input is left as it is. The hold ends once the instruction that follows the protected write has completed, which the processor signals with `instr_done`.

A dispatch is registered. `vec_valid` and a one-hot `irq_ack` pulse for one cycle, and `vec_addr` is presented with them. The requesting source uses the acknowledge to clear its flag.

Top module: `ivec_ctrl`

## Requirements
- R1: `reset_addr` is `0x0000` when `boot_fuse_n` is 1 and `0x3800` (the boot base) when it is 0.
- R2: A dispatch of source k (k = 0..19) drives `vec_addr` = base + 2k. The base is `0x0002` when vector-select is 0 and `0x3802` when it is 1, whatever the level of `boot_fuse_n`.
- R3: Only sources with both `irq_pend[k]` and `irq_en[k]` set compete, and the lowest k wins. `irq_ack` is one-hot on the winner, or zero when there is no dispatch.
- R4: A dispatch decided at a clock edge appears in `vec_valid`/`irq_ack`/`vec_addr` right after that edge. No dispatch happens while `gie` is 0. `vec_valid` is never high on two consecutive cycles.
- R5: The control register reads as follows: bits 7:5 are read/write enable bits, also driven on `ext_en`; bits 4:2 read 0; bit 1 is vector-select; bit 0 is change-enable. Every bit is 0 after reset.
- R6: Vector-select takes `wr_data[1]` only from a write with `wr_data[0]`=0 that arrives while change-enable is 1. Every other write leaves it unchanged. Such a write is accepted in each of the four cycles after the write that set change-enable, and rejected from the fifth cycle on.
- R7: Change-enable reads 1 for exactly four cycles after a write with bit 0 = 1, then clears by itself. An accepted vector-select write clears it at once.
- R8: Dispatch is blocked at the edge of the write that sets change-enable and for as long as change-enable is 1, including the edge at which it times out. After an accepted vector-select write, dispatch stays blocked through the edge at which `instr_done` is sampled high. Dispatch then resumes without `gie` being touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_fuse_n | input | 1 | Reset location strap, 0 = boot region |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read data |
| ext_en | output | 3 | Enable bits 7:5 of the control register |
| instr_done | input | 1 | Pulse marking completion of an instruction |
| gie | input | 1 | Global interrupt enable |
| irq_pend | input | 20 | Pending request per source |
| irq_en | input | 20 | Enable per source |
| reset_addr | output | 14 | Word address fetched after reset |
| vec_addr | output | 14 | Vector word address of the dispatched source |
| vec_valid | output | 1 | One-cycle dispatch strobe |
| irq_ack | output | 20 | One-hot acknowledge to the dispatched source |

## Verification
The bench targets the edges of the unlock window. A write on the fourth cycle after the arming write must be accepted, and one on the fifth must be rejected. A design that counts one cycle short or long would flip vector-select on the wrong write. The bench also holds a request pending through the whole sequence. A controller that lifts the mask at the protected write, or forgets it after a timeout, would dispatch early from the old table. Priority checks pair a disabled higher source with an enabled lower one, which exposes an arbiter that looks at pending flags alone. A held request checks that one request does not produce back-to-back strobes.

// File: rtl/ivec_pkg.sv
// Package: shared constants for the relocatable interrupt vector controller.
// Assumes word addressing and two words per vector entry.
package ivec_pkg;
    localparam int unsigned IVEC_NUM_SRC   = 20;
    localparam int unsigned IVEC_ADDR_W    = 14;
    localparam int unsigned IVEC_WIN       = 4;
    localparam logic [13:0] IVEC_BOOT_BASE = 14'h3800;

    // Bit positions inside the control register.
    localparam int unsigned CTL_CEN_BIT  = 0;
    localparam int unsigned CTL_VSEL_BIT = 1;
    localparam int unsigned CTL_EXT_LSB  = 5;
endpackage

// File: rtl/ivec_ctl_reg.sv
// Module: control register with the guarded vector-select bit.
// Holds the three enable bits, vector-select and change-enable. Produces the
// dispatch mask for the unlock window and the post-write hold.
// Assumes at most one register write per cycle.
module ivec_ctl_reg #(
    parameter int unsigned WIN = ivec_pkg::IVEC_WIN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       instr_done,
    output logic [7:0] rd_data,
    output logic [2:0] ext_en,
    output logic       vsel,
    output logic       mask
);
    import ivec_pkg::*;
    localparam int unsigned CNT_W = (WIN > 1) ? $clog2(WIN) : 1;

    logic             cen_q, vsel_q, hold_q;
    logic [2:0]       ext_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_arm, wr_sel;

    // Decode the write kinds: arming write and accepted select write.
    assign wr_arm = wr_en &  wr_data[CTL_CEN_BIT];
    assign wr_sel = wr_en & ~wr_data[CTL_CEN_BIT] & cen_q;

    // Register state, unlock window countdown and post-write hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q  <= 1'b0;
            vsel_q <= 1'b0;
            hold_q <= 1'b0;
            ext_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_en) ext_q <= wr_data[CTL_EXT_LSB +: 3];
            if (wr_arm) begin
                cen_q <= 1'b1;
                cnt_q <= CNT_W'(WIN - 1);
            end else if (wr_sel) begin
                cen_q  <= 1'b0;
                vsel_q <= wr_data[CTL_VSEL_BIT];
            end else if (cen_q) begin
                if (cnt_q == '0) cen_q <= 1'b0;
                else             cnt_q <= cnt_q - 1'b1;
            end
            if (wr_sel)          hold_q <= 1'b1;
            else if (instr_done) hold_q <= 1'b0;
        end
    end

    // Mask covers the arming edge, the open window and the hold.
    assign mask    = wr_arm | cen_q | hold_q;
    assign vsel    = vsel_q;
    assign ext_en  = ext_q;
    assign rd_data = {ext_q, 3'b000, vsel_q, cen_q};

    // Checker counter: cycles change-enable has been high since it was armed.
    logic [3:0] cen_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           cen_age_q <= '0;
        else if (wr_arm)      cen_age_q <= '0;
        else if (cen_q)       cen_age_q <= cen_age_q + 1'b1;
        else                  cen_age_q <= '0;
    end

    // R6: vector-select only moves after a cycle with change-enable set.
    assert_vsel_guarded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vsel_q != $past(vsel_q)) |-> $past(cen_q));
    // R7: change-enable never stays high past the window length.
    assert_cen_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cen_q |-> (32'(cen_age_q) < WIN));
endmodule

// File: rtl/ivec_arbiter.sv
// Module: fixed-priority arbiter, the lowest index wins.
// Purely combinational. Assumes the requests are already qualified by enable.
module ivec_arbiter #(
    parameter int unsigned N = ivec_pkg::IVEC_NUM_SRC
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int unsigned IDX_W = $clog2(N);

    // One-hot grant: a request wins when no lower index requests.
    for (genvar i = 0; i < N; i++) begin : g_grant
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    // Binary index of the winner, scanning downward so the lowest stays.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/ivec_addr_gen.sv
// Module: reset and vector address generation.
// The table base follows vector-select. Reset follows the strap.
// Assumes two words per vector entry.
module ivec_addr_gen #(
    parameter int unsigned        N         = ivec_pkg::IVEC_NUM_SRC,
    parameter int unsigned        ADDR_W    = ivec_pkg::IVEC_ADDR_W,
    parameter logic [ADDR_W-1:0]  BOOT_BASE = ivec_pkg::IVEC_BOOT_BASE
) (
    input  logic                 boot_fuse_n,
    input  logic                 vsel,
    input  logic [$clog2(N)-1:0] idx,
    output logic [ADDR_W-1:0]    reset_addr,
    output logic [ADDR_W-1:0]    vec_addr
);
    localparam logic [ADDR_W-1:0] FIRST_VEC = ADDR_W'(2);
    logic [ADDR_W-1:0] base;

    // Reset target and table base selection.
    assign reset_addr = boot_fuse_n ? '0 : BOOT_BASE;
    assign base       = vsel ? (BOOT_BASE + FIRST_VEC) : FIRST_VEC;
    // Entry offset is twice the source index.
    assign vec_addr   = base + (ADDR_W'(idx) << 1);
endmodule

// File: rtl/ivec_ctrl.sv
// Module: top of the relocatable interrupt vector controller.
// Qualifies the requests, arbitrates and registers a one-cycle dispatch.
// Assumes the source drops its request after the acknowledge; a held request
// is re-dispatched no sooner than two cycles later.
module ivec_ctrl #(
    parameter int unsigned       NUM_SRC   = ivec_pkg::IVEC_NUM_SRC,
    parameter int unsigned       ADDR_W    = ivec_pkg::IVEC_ADDR_W,
    parameter int unsigned       WIN       = ivec_pkg::IVEC_WIN,
    parameter logic [ADDR_W-1:0] BOOT_BASE = ivec_pkg::IVEC_BOOT_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_fuse_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic [2:0]         ext_en,
    input  logic               instr_done,
    input  logic               gie,
    input  logic [NUM_SRC-1:0] irq_pend,
    input  logic [NUM_SRC-1:0] irq_en,
    output logic [ADDR_W-1:0]  reset_addr,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               vec_valid,
    output logic [NUM_SRC-1:0] irq_ack
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC);

    logic               vsel, mask, any, go;
    logic [NUM_SRC-1:0] req, grant;
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  addr_next;

    ivec_ctl_reg #(.WIN(WIN)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .instr_done(instr_done), .rd_data(rd_data), .ext_en(ext_en),
        .vsel(vsel), .mask(mask)
    );

    assign req = irq_pend & irq_en;

    ivec_arbiter #(.N(NUM_SRC)) u_arb (
        .req(req), .grant(grant), .idx(idx), .any(any)
    );

    ivec_addr_gen #(.N(NUM_SRC), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_addr (
        .boot_fuse_n(boot_fuse_n), .vsel(vsel), .idx(idx),
        .reset_addr(reset_addr), .vec_addr(addr_next)
    );

    // Dispatch is allowed when enabled, unmasked, and not right after a dispatch.
    assign go = any & gie & ~mask & ~vec_valid;

    // Register the dispatch strobe, acknowledge and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            irq_ack   <= '0;
            vec_addr  <= '0;
        end else begin
            vec_valid <= go;
            irq_ack   <= go ? grant : '0;
            if (go) vec_addr <= addr_next;
        end
    end

    // R3: the acknowledge is one-hot or empty and tracks the strobe.
    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack) && (vec_valid == (|irq_ack)));
    // R3: the acknowledged source was enabled and pending.
    assert_ack_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((irq_ack & $past(irq_pend & irq_en)) == irq_ack));
    // R4: no dispatch with the global enable clear.
    assert_gie_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !vec_valid);
    // R4: no back-to-back strobes.
    assert_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R8: the unlock mask suppresses dispatch.
    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !vec_valid);
endmodule

// File: tb/ivec_ctrl_tb_top.sv
// Bench: a table of arbitration vectors, then directed tests of reset,
// the unlock window, its edges and the dispatch mask.
module ivec_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_fuse_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [2:0]  ext_en;
    logic        instr_done = 1'b0;
    logic        gie = 1'b0;
    logic [19:0] irq_pend = '0;
    logic [19:0] irq_en = '0;
    logic [13:0] reset_addr, vec_addr;
    logic        vec_valid;
    logic [19:0] irq_ack;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ivec_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .boot_fuse_n(boot_fuse_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ext_en(ext_en),
        .instr_done(instr_done), .gie(gie), .irq_pend(irq_pend),
        .irq_en(irq_en), .reset_addr(reset_addr), .vec_addr(vec_addr),
        .vec_valid(vec_valid), .irq_ack(irq_ack)
    );

    typedef struct packed {
        logic [19:0] pend;
        logic [19:0] en;
        logic        valid;
        logic [13:0] addr;
        logic [19:0] ack;
    } vec_t;

    // Arbitration cases with vector-select 0 and gie 1.
    localparam vec_t TBL [8] = '{
        '{20'h00001, 20'hFFFFF, 1'b1, 14'h0002, 20'h00001},
        '{20'h80000, 20'hFFFFF, 1'b1, 14'h0028, 20'h80000},
        '{20'h00C00, 20'hFFFFF, 1'b1, 14'h0016, 20'h00400},
        '{20'h00C00, 20'hFFBFF, 1'b1, 14'h0018, 20'h00800},
        '{20'hFFFFF, 20'h00000, 1'b0, 14'h0000, 20'h00000},
        '{20'h00000, 20'hFFFFF, 1'b0, 14'h0000, 20'h00000},
        '{20'h41020, 20'h40000, 1'b1, 14'h0026, 20'h40000},
        '{20'hFFFFE, 20'hFFFFF, 1'b1, 14'h0004, 20'h00002}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Advance one edge and land 1 ns after it, away from the next edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        tick(); tick();
        // R5/R4 reset state, R1 reset target from the strap.
        check("R5 reset rd_data", 32'(rd_data), 32'h00);
        check("R4 reset vec_valid", 32'(vec_valid), 32'h0);
        check("R1 fuse=1 reset_addr", 32'(reset_addr), 32'h0000);
        boot_fuse_n = 1'b0; #1;
        check("R1 fuse=0 reset_addr", 32'(reset_addr), 32'h3800);
        boot_fuse_n = 1'b1;
        rst_n = 1'b1;
        tick();

        // R3/R2: table walk.
        gie = 1'b1;
        foreach (TBL[i]) begin
            irq_pend = TBL[i].pend; irq_en = TBL[i].en;
            tick();
            check($sformatf("R3 vec%0d valid", i), 32'(vec_valid), 32'(TBL[i].valid));
            check($sformatf("R3 vec%0d ack", i), 32'(irq_ack), 32'(TBL[i].ack));
            if (TBL[i].valid)
                check($sformatf("R2 vec%0d addr", i), 32'(vec_addr), 32'(TBL[i].addr));
            irq_pend = '0;
            tick();
        end

        // R4: gie low blocks, then a held request pulses every other cycle.
        irq_en = '1; irq_pend = 20'h00010; gie = 1'b0;
        tick();
        check("R4 gie=0 no dispatch", 32'(vec_valid), 32'h0);
        gie = 1'b1;
        tick();
        check("R4 held req first strobe", 32'(vec_valid), 32'h1);
        check("R2 source 4 addr", 32'(vec_addr), 32'h000A);
        tick();
        check("R4 no back-to-back", 32'(vec_valid), 32'h0);
        tick();
        check("R4 held req again", 32'(vec_valid), 32'h1);
        irq_pend = '0;
        tick();

        // R5/R6: write without arming; enables land, vector-select does not.
        reg_write(8'hFE);
        check("R6 unarmed write rd_data", 32'(rd_data), 32'hE0);
        check("R5 ext_en", 32'(ext_en), 32'h7);

        // R8/R6/R7: protected sequence with a request pending throughout.
        irq_pend = 20'h00008;
        reg_write(8'h01);
        check("R8 arming edge blocks", 32'(vec_valid), 32'h0);
        check("R7 cen set rd_data", 32'(rd_data), 32'h01);
        reg_write(8'h02);
        check("R6 accepted select rd_data", 32'(rd_data), 32'h02);
        check("R8 window blocks", 32'(vec_valid), 32'h0);
        tick();
        check("R8 hold blocks", 32'(vec_valid), 32'h0);
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;
        check("R8 hold through instr_done edge", 32'(vec_valid), 32'h0);
        tick();
        check("R8 resumes after hold", 32'(vec_valid), 32'h1);
        check("R2 boot table source 3", 32'(vec_addr), 32'h3808);
        irq_pend = '0;
        tick();

        // R7/R8: arm and time out with a request pending.
        irq_pend = 20'h00001;
        reg_write(8'h03);
        check("R6 arming write keeps vsel", 32'(rd_data), 32'h03);
        for (int k = 1; k <= 3; k++) begin
            tick();
            check($sformatf("R8 timeout window cycle %0d", k), 32'(vec_valid), 32'h0);
        end
        check("R7 cen still set at cycle 3", 32'(rd_data[0]), 32'h1);
        tick();
        check("R7 cen cleared at cycle 4", 32'(rd_data[0]), 32'h0);
        check("R8 timeout edge blocks", 32'(vec_valid), 32'h0);
        tick();
        check("R8 resumes after timeout", 32'(vec_valid), 32'h1);
        check("R2 boot table source 0", 32'(vec_addr), 32'h3802);
        irq_pend = '0;
        tick();

        // R6: write on the fifth cycle after arming is rejected.
        reg_write(8'h01);
        for (int k = 1; k <= 4; k++) tick();
        reg_write(8'h00);
        check("R6 late write rejected", 32'(rd_data), 32'h02);

        // R6: write on the fourth cycle after arming is accepted.
        reg_write(8'h01);
        for (int k = 1; k <= 3; k++) tick();
        reg_write(8'h00);
        check("R6 fourth-cycle write accepted", 32'(rd_data), 32'h00);
        instr_done = 1'b1;
        tick();
        instr_done = 1'b0;

        // R2: back in the application table, fuse programmed has no effect.
        boot_fuse_n = 1'b0;
        irq_pend = 20'h80000;
        tick();
        check("R2 app table with fuse=0", 32'(vec_addr), 32'h0028);
        check("R1 fuse=0 reset_addr", 32'(reset_addr), 32'h3800);
        irq_pend = '0;
        tick();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule